// File: doc/BRIEF.md
# Interval, Fixed-Tick and Watchdog Timer Unit

This unit gives a processor three timing services built on one 64-bit time base that advances on every clock. An interval down-counter produces an event a programmed number of clocks after it is loaded, and can restart itself from the stored load value to give a steady periodic tick. A fixed-tick source produces an event each time a chosen power-of-two bit of the time base falls. A two-stage watchdog marks a pending expiry first. If software has not cleared that mark by the next expiry, it issues a one-cycle reset request.

Software uses a small strobe-based register port with five word addresses: control, status, interval load/count, and the two halves of the time base. Each pending event has a status bit, and software clears a bit by writing a one to it. A single interrupt line combines the enabled events. The reset request carries a 2-bit code that tells a separate reset controller how far the reset should reach.

Top module: `tick_watch_unit`

## Requirements
- R1: After reset, control reads 0, status reads 0, the interval count reads 0, `irq` is 0 and `rst_req` is 0.
- R2: The time base increases by one every clock. A write to address 3 stages a low word, and a following write to address 4 sets the whole 64-bit value to {high, staged low}. Reading address 3 returns the low word and captures the high word at the same instant, and a later read of address 4 returns that captured word.
- R3: Writing N to address 2 loads the interval counter, which then counts down once per clock. Status bit 0 is set on the clock the count goes from 1 to 0, which is N clocks after the write. Reading address 2 returns the live count. With auto-reload off, the count stays at 0.
- R4: With control bit 22 set, the counter reloads the last written value instead of stopping at 0, so status bit 0 is set every N clocks.
- R5: Writing status (address 1) clears each bit written as 1. Bits written as 0 keep their value.
- R6: `irq` is a registered OR over three pairs: status bit 0 with control bit 26, status bit 1 with control bit 23, and status bit 2 with control bit 27. It changes one clock after the status or control register it depends on.
- R7: Status bit 1 is set one clock after time-base bit FIX_BASE+FIX_STEP*c-1 goes from 1 to 0, where c is control bits 25:24.
- R8: On a watchdog expiry with status bit 2 clear, status bit 2 is set one clock later. An expiry is a 1-to-0 fall of time-base bit WD_BASE+WD_STEP*w-1, where w is control bits 31:30.
- R9: On an expiry while status bit 2 is set, status bit 3 is set and `rst_req` carries control bits 29:28 for exactly one clock.
- R10: Clearing status bit 2 between two expiries prevents the reset request at the second one.
- R11: Addresses are 0 control, 1 status, 2 interval, 3 time-base low and 4 time-base high. Control keeps only bits 31:22 and reads 0 in bits 21:0. Read data appears the clock after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 1 | Combined timer interrupt, registered |
| rst_req | output | 2 | Reset request code, asserted for one clock |

## Verification
The bench builds the unit with FIX_BASE=3, FIX_STEP=1, WD_BASE=5 and WD_STEP=1. This gives fixed-tick periods of 8 and 16 clocks and a watchdog period of 32 clocks. With those periods, two watchdog expiries, the one-clock reset pulse and a clear between expiries all happen within about a hundred cycles. The time base keeps its full 64-bit default width, so the bench loads a value just below a 32-bit boundary and watches the carry reach the captured high word. The counter keeps its 32-bit width, and the bench checks both the one-shot hold and the exact reload cadence.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int WORD_W   = 32;
  localparam int CTRL_LSB = 22;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_IVAL = 3'd2,
    A_TBLO = 3'd3,
    A_TBHI = 3'd4
  } reg_addr_e;

  localparam int ST_IVL = 0;
  localparam int ST_FIX = 1;
  localparam int ST_WDG = 2;
  localparam int ST_RST = 3;
  localparam int ST_W   = 4;

  typedef struct packed {
    logic [1:0] wd_per;
    logic [1:0] wd_act;
    logic       wd_ie;
    logic       ivl_ie;
    logic [1:0] fix_per;
    logic       fix_ie;
    logic       auto_rl;
  } ctrl_t;
endpackage

// File: rtl/tw_timebase.sv
module tw_timebase #(
  parameter int TB_W = 64,
  localparam int LO_W = 32,
  localparam int HI_W = TB_W - LO_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [31:0]     wdata,
  input  logic            snap_en,
  output logic [TB_W-1:0] tb,
  output logic [HI_W-1:0] hi_snap
);
  logic [LO_W-1:0] lo_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      tb       <= '0;
      lo_stage <= '0;
      hi_snap  <= '0;
    end else begin
      if (wr_lo)
        lo_stage <= wdata[LO_W-1:0];
      if (wr_hi)
        tb <= {wdata[HI_W-1:0], lo_stage};
      else
        tb <= tb + TB_W'(1);
      if (snap_en)
        hi_snap <= tb[TB_W-1:LO_W];
    end
  end

  // R2: free-running step of one per clock
  a_r2_tb_step: assert property (@(posedge clk) disable iff (rst)
    !wr_hi |=> tb == $past(tb) + TB_W'(1));

  // R2: high write commits the staged low word
  a_r2_tb_load: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> tb[LO_W-1:0] == $past(lo_stage));
endmodule

// File: rtl/tw_interval.sv
module tw_interval #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             auto_rl,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  logic [CNT_W-1:0] reload;
  logic             at_one;

  assign at_one = (count == CNT_W'(1));
  assign fire   = at_one && !load_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      reload <= '0;
    end else if (load_wr) begin
      count  <= load_val;
      reload <= load_val;
    end else if (at_one) begin
      count <= auto_rl ? reload : '0;
    end else if (count != '0) begin
      count <= count - CNT_W'(1);
    end
  end

  // R3: decrement by one while above one
  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (count > CNT_W'(1) && !load_wr) |=> count == $past(count) - CNT_W'(1));

  // R3: one-shot holds at zero
  a_r3_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !load_wr) |=> count == '0);

  // R4: reload from the stored value
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (fire && auto_rl) |=> count == $past(reload));
endmodule

// File: rtl/tw_tap_fall.sv
module tw_tap_fall #(
  parameter int TB_W = 64,
  parameter int BASE = 9,
  parameter int STEP = 4,
  localparam int N_SEL = 4,
  localparam int SEL_W = $clog2(N_SEL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TB_W-1:0]  tb,
  input  logic [SEL_W-1:0] sel,
  output logic             fall
);
  logic [N_SEL-1:0] taps;
  logic             cur_bit;
  logic             prev_bit;
  logic             tb_unused;

  for (genvar g = 0; g < N_SEL; g++) begin : g_tap
    localparam int IDX = BASE + STEP * g - 1;
    assign taps[g] = tb[IDX];
  end

  assign tb_unused = ^tb;
  assign cur_bit   = taps[sel];
  assign fall      = prev_bit && !cur_bit;

  always_ff @(posedge clk) begin
    if (rst) prev_bit <= 1'b0;
    else     prev_bit <= cur_bit;
  end

  // R7: an event lasts a single clock
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog (
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  logic       pending,
  input  logic [1:0] action,
  output logic       set_pend,
  output logic       set_rst,
  output logic [1:0] rst_req
);
  assign set_pend = expire && !pending;
  assign set_rst  = expire && pending;

  always_ff @(posedge clk) begin
    if (rst)          rst_req <= 2'b00;
    else if (set_rst) rst_req <= action;
    else              rst_req <= 2'b00;
  end

  // R9: reset request lasts exactly one clock
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (rst_req != 2'b00) |=> rst_req == 2'b00);

  // R9: request code follows the selected action
  a_r9_code: assert property (@(posedge clk) disable iff (rst)
    set_rst |=> rst_req == $past(action));
endmodule

// File: rtl/tick_watch_unit.sv
module tick_watch_unit #(
  parameter int TB_W     = 64,
  parameter int CNT_W    = 32,
  parameter int FIX_BASE = 9,
  parameter int FIX_STEP = 4,
  parameter int WD_BASE  = 17,
  parameter int WD_STEP  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic [1:0]  rst_req
);
  import tw_pkg::*;

  localparam int HI_W = TB_W - 32;

  ctrl_t            ctrl;
  logic [ST_W-1:0]  status;
  logic [ST_W-1:0]  st_clr;
  logic [ST_W-1:0]  st_set;
  logic [ST_W-1:0]  irq_mask;
  logic [TB_W-1:0]  tb;
  logic [HI_W-1:0]  hi_snap;
  logic [CNT_W-1:0] ivl_cnt;
  logic             ivl_fire;
  logic             fix_fall;
  logic             wd_exp;
  logic             wd_set_pend;
  logic             wd_set_rst;

  logic wr_ctrl, wr_stat, wr_ivl, wr_tblo, wr_tbhi, rd_tblo;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_ivl  = wr_en && (addr == A_IVAL);
  assign wr_tblo = wr_en && (addr == A_TBLO);
  assign wr_tbhi = wr_en && (addr == A_TBHI);
  assign rd_tblo = rd_en && (addr == A_TBLO);

  tw_timebase #(.TB_W(TB_W)) u_timebase (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (wr_tblo),
    .wr_hi   (wr_tbhi),
    .wdata   (wdata),
    .snap_en (rd_tblo),
    .tb      (tb),
    .hi_snap (hi_snap)
  );

  tw_interval #(.CNT_W(CNT_W)) u_interval (
    .clk      (clk),
    .rst      (rst),
    .load_wr  (wr_ivl),
    .load_val (wdata[CNT_W-1:0]),
    .auto_rl  (ctrl.auto_rl),
    .count    (ivl_cnt),
    .fire     (ivl_fire)
  );

  tw_tap_fall #(.TB_W(TB_W), .BASE(FIX_BASE), .STEP(FIX_STEP)) u_fix_tap (
    .clk  (clk),
    .rst  (rst),
    .tb   (tb),
    .sel  (ctrl.fix_per),
    .fall (fix_fall)
  );

  tw_tap_fall #(.TB_W(TB_W), .BASE(WD_BASE), .STEP(WD_STEP)) u_wd_tap (
    .clk  (clk),
    .rst  (rst),
    .tb   (tb),
    .sel  (ctrl.wd_per),
    .fall (wd_exp)
  );

  tw_watchdog u_watchdog (
    .clk      (clk),
    .rst      (rst),
    .expire   (wd_exp),
    .pending  (status[ST_WDG]),
    .action   (ctrl.wd_act),
    .set_pend (wd_set_pend),
    .set_rst  (wd_set_rst),
    .rst_req  (rst_req)
  );

  always_comb begin
    st_clr = wr_stat ? wdata[ST_W-1:0] : '0;
    st_set = '0;
    st_set[ST_IVL] = ivl_fire;
    st_set[ST_FIX] = fix_fall;
    st_set[ST_WDG] = wd_set_pend;
    st_set[ST_RST] = wd_set_rst;
    irq_mask = '0;
    irq_mask[ST_IVL] = ctrl.ivl_ie;
    irq_mask[ST_FIX] = ctrl.fix_ie;
    irq_mask[ST_WDG] = ctrl.wd_ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_ctrl)
        ctrl <= ctrl_t'(wdata[WORD_W-1:CTRL_LSB]);
      status <= (status & ~st_clr) | st_set;
      irq    <= |(status & irq_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_CTRL:  rdata <= {ctrl, {CTRL_LSB{1'b0}}};
        A_STAT:  rdata <= 32'(status);
        A_IVAL:  rdata <= 32'(ivl_cnt);
        A_TBLO:  rdata <= tb[31:0];
        A_TBHI:  rdata <= 32'(hi_snap);
        default: rdata <= '0;
      endcase
    end
  end

  // R5: write-one clears a bit that is not being set
  a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata[ST_IVL] && !ivl_fire) |=> !status[ST_IVL]);

  // R8: first expiry marks the watchdog pending
  a_r8_first_stage: assert property (@(posedge clk) disable iff (rst)
    (wd_exp && !status[ST_WDG]) |=> status[ST_WDG] && rst_req == 2'b00);

  // R10: no reset request without a pending mark
  a_r10_needs_pending: assert property (@(posedge clk) disable iff (rst)
    (wd_exp && !status[ST_WDG]) |=> !status[ST_RST] || $past(status[ST_RST]));
endmodule

// File: tb/tick_watch_unit_bench.sv
`timescale 1ns/1ps
module tick_watch_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [1:0]  rst_req;

  always #2 clk = ~clk;

  tick_watch_unit #(
    .TB_W(64), .CNT_W(32),
    .FIX_BASE(3), .FIX_STEP(1),
    .WD_BASE(5), .WD_STEP(1)
  ) u_tick_watch_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  localparam logic [31:0] PIE   = 32'h1 << 26;
  localparam logic [31:0] ARE   = 32'h1 << 22;
  localparam logic [31:0] FIE   = 32'h1 << 23;
  localparam logic [31:0] WIE   = 32'h1 << 27;
  localparam logic [31:0] FIT1  = 32'h1 << 24;
  localparam logic [31:0] WACT2 = 32'h2 << 28;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   base = 0;
  int   pulses = 0;
  logic rd_q = 1'b0;
  bit   done = 1'b0;

  logic [31:0] q_exp[$];
  logic [31:0] q_msk[$];
  string       q_tag[$];

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    rd_q <= rd_en;
  end

  always @(negedge clk) if (rst_req != 2'b00) pulses++;

  // monitor: compares each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_q) begin
      n_chk++;
      if (q_exp.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: read with no expectation act=%h exp=none", rdata);
      end else begin
        logic [31:0] e, m;
        string t;
        e = q_exp.pop_front();
        m = q_msk.pop_front();
        t = q_tag.pop_front();
        if ((rdata & m) !== (e & m)) begin
          n_bad++;
          $display("FAIL %s: act=%h exp=%h", t, rdata & m, e & m);
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, logic [31:0] m, string tag);
    q_exp.push_back(e); q_msk.push_back(m); q_tag.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic mark();
    base = cyc;
  endtask

  // next operation lands on edge number t after the marked one
  task automatic go(int t);
    while (cyc - base < t - 1) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=timeout exp=finished");
    summary();
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(3'd0, 32'h0, 32'hFFFF_FFFF, "R1 ctrl after reset");
    rd(3'd1, 32'h0, 32'h0000_000F, "R1 status after reset");
    rd(3'd2, 32'h0, 32'hFFFF_FFFF, "R1 count after reset");
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 rst_req after reset", 32'(rst_req), 32'h0);

    // R11 control keeps only the upper field
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'hFFC0_0000, 32'hFFFF_FFFF, "R11 ctrl readback");
    wr(3'd0, 32'h0);

    // R3 one-shot, R6 masking, R5 write-one-to-clear
    wr(3'd2, 32'd10); mark();
    go(10); rd(3'd1, 32'h0, 32'h1, "R3 not yet expired");
    rd(3'd1, 32'h1, 32'h1, "R3 expired after N clocks");
    chk("R6 irq masked", 32'(irq), 32'h0);
    wr(3'd0, PIE);
    chk("R6 irq one clock after enable", 32'(irq), 32'h0);
    rd(3'd2, 32'h0, 32'hFFFF_FFFF, "R3 count holds at zero");
    chk("R6 irq enabled", 32'(irq), 32'h1);
    wr(3'd1, 32'h0);
    rd(3'd1, 32'h1, 32'h1, "R5 zero write keeps bit");
    wr(3'd1, 32'h1);
    rd(3'd1, 32'h0, 32'h1, "R5 one write clears bit");
    chk("R6 irq drops after clear", 32'(irq), 32'h0);

    // R4 auto-reload cadence
    wr(3'd0, PIE | ARE);
    wr(3'd2, 32'd6); mark();
    go(20); rd(3'd2, 32'd5, 32'hFFFF_FFFF, "R4 reloaded count");
    rd(3'd1, 32'h1, 32'h1, "R4 periodic event");
    wr(3'd1, 32'h1);
    rd(3'd1, 32'h0, 32'h1, "R4 cleared");
    rd(3'd1, 32'h0, 32'h1, "R4 before next period");
    rd(3'd1, 32'h1, 32'h1, "R4 next period");
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h0);

    // R2 time base load, step and snapshot
    wr(3'd3, 32'hFFFF_FFF0);
    wr(3'd4, 32'h0000_0005); mark();
    rd(3'd3, 32'hFFFF_FFF0, 32'hFFFF_FFFF, "R2 low after load");
    rd(3'd4, 32'h0000_0005, 32'hFFFF_FFFF, "R2 high snapshot");
    go(21); rd(3'd3, 32'h0000_0004, 32'hFFFF_FFFF, "R2 low after carry");
    rd(3'd4, 32'h0000_0006, 32'hFFFF_FFFF, "R2 high after carry");

    // R7 fixed tick, code 0 -> bit 2
    wr(3'd0, FIE);
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd0); mark();
    go(2); wr(3'd1, 32'hF);
    go(4); rd(3'd1, 32'h0, 32'h2, "R7 before fall");
    chk("R6 fixed irq still low", 32'(irq), 32'h0);
    rd(3'd1, 32'h2, 32'h2, "R7 after fall of bit 2");
    chk("R6 fixed irq", 32'(irq), 32'h1);

    // R7 fixed tick, code 1 -> bit 3
    wr(3'd0, FIE | FIT1);
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd0); mark();
    go(2); wr(3'd1, 32'hF);
    go(8); rd(3'd1, 32'h0, 32'h2, "R7 code1 ignores bit 2");
    go(12); rd(3'd1, 32'h0, 32'h2, "R7 code1 before fall");
    rd(3'd1, 32'h2, 32'h2, "R7 code1 after fall of bit 3");

    // R8 / R9 / R10 watchdog, code 0 -> bit 4, action 2
    wr(3'd0, WIE | WACT2);
    wr(3'd3, 32'd28);
    wr(3'd4, 32'd0); mark();
    go(2); wr(3'd1, 32'hF);
    go(5); rd(3'd1, 32'h0, 32'h4, "R8 before first expiry");
    chk("R6 watchdog irq low", 32'(irq), 32'h0);
    rd(3'd1, 32'h4, 32'hC, "R8 first expiry pending");
    chk("R6 watchdog irq", 32'(irq), 32'h1);
    go(37);
    chk("R9 no request before second expiry", 32'(rst_req), 32'h0);
    step();
    chk("R9 request code", 32'(rst_req), 32'h2);
    step();
    chk("R9 request lasts one clock", 32'(rst_req), 32'h0);
    rd(3'd1, 32'hC, 32'hC, "R9 reset pending bit");
    wr(3'd1, 32'hF);
    p0 = pulses;
    go(75); wr(3'd1, 32'hF);
    go(102); rd(3'd1, 32'h4, 32'hC, "R10 cleared mark avoids reset");
    step();
    chk("R10 no reset request pulse", 32'(pulses), 32'(p0));

    step(); step();
    summary();
  end
endmodule